// File: doc/BRIEF.md
# Paired-Lane Float Compare into Condition Field

This block compares single-precision IEEE-754 values and records the verdict as a 4-bit code in a selected field of a 32-bit condition register. Each operand is 64 bits wide and holds two 32-bit lanes. The low lane is bits 31:0 and the high lane is bits 63:32. In scalar mode only the low lanes are compared. In vector mode both lanes are compared independently and the code packs both verdicts together.

Each lane first sorts its operand pair into one of four outcomes: less, equal, greater or unordered. The requested relation is then tested against that outcome. An unordered pair (either operand a NaN) never satisfies any relation. A signaling NaN in a lane that takes part in the compare sets an invalid-operation flag. That flag stays set until reset.

Updates happen on the clock edge that samples the valid strobe. Only the addressed nibble of the condition register changes.

Top module: `lane_fcmp_crfield`

## Requirements
- R1: In scalar mode (`vec_i`=0) the written nibble is 4'b0100 when the relation holds on the low 32-bit words and 4'b0000 otherwise; bits 63:32 of both operands have no effect on the nibble or on the flag.
- R2: In vector mode (`vec_i`=1) the written nibble is, from bit 3 down to bit 0: high-lane hit, low-lane hit, high OR low, high AND low.
- R3: Field index f rewrites condition bits [(7-f)*4+3 : (7-f)*4], so field 0 is bits 31:28 and field 7 is bits 3:0; the other 28 bits keep their value.
- R4: Relation code `rel_i` 2'b00 tests equal, 2'b01 tests a greater than b, 2'b10 tests a less than b, and 2'b11 never holds.
- R5: If either operand in a lane is a NaN (exponent all ones and fraction nonzero), that lane's hit is 0 for every relation.
- R6: Ordering follows sign and magnitude: +0 and -0 are equal, a positive value exceeds any negative one, two negatives order by reversed magnitude, and denormals order by value.
- R7: The invalid flag is raised only when a participating lane holds a signaling NaN (exponent all ones, fraction nonzero, fraction bit 22 clear); quiet NaNs (bit 22 set) do not raise it.
- R8: Once set, `inv_o` stays 1 through all further operations until reset.
- R9: The register and flag change only on the rising clock edge at which `valid_i` is 1; with `valid_i`=0 both hold.
- R10: A rising edge with `rst_n`=0 clears `cr_o` to zero and `inv_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Perform a compare on this edge |
| vec_i | input | 1 | 0: scalar on low lane, 1: both lanes |
| rel_i | input | 2 | Relation code (see R4) |
| field_i | input | 3 | Target condition field index |
| opa_i | input | 64 | Operand a, high lane 63:32, low lane 31:0 |
| opb_i | input | 64 | Operand b, same lane layout |
| cr_o | output | 32 | Condition register |
| inv_o | output | 1 | Sticky invalid-operation flag |

## Verification
The bench uses the default package values: 32-bit lanes with an 8-bit exponent, two lanes, and eight 4-bit fields. With these values every field index, both lane positions and all four relation codes can be reached. The reference model turns each word into a real number by scaling its significand. It therefore orders values, including signed zeros, denormals and infinities, without comparing bit patterns. Directed cases cover NaNs of both kinds placed in each lane and in the ignored high word of a scalar compare.

// File: rtl/lane_fcmp_pkg.sv
package lane_fcmp_pkg;

    localparam int WORD_W = 32;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int LANES  = 2;
    localparam int FIELDS = 8;
    localparam int NIB_W  = 4;

    localparam int CR_W   = FIELDS * NIB_W;
    localparam int FIDX_W = $clog2(FIELDS);
    localparam int SH_W   = $clog2(CR_W);
    localparam int OP_W   = LANES * WORD_W;

    typedef enum logic [1:0] {
        CMP_LT = 2'd0,
        CMP_EQ = 2'd1,
        CMP_GT = 2'd2,
        CMP_UN = 2'd3
    } cmp_out_e;

    typedef enum logic [1:0] {
        REL_EQ   = 2'd0,
        REL_GT   = 2'd1,
        REL_LT   = 2'd2,
        REL_NONE = 2'd3
    } rel_e;

    typedef struct packed {
        logic [CR_W-1:0] cr;
        logic            inv;
    } state_t;

endpackage

// File: rtl/lane_fcmp_lane.sv
module lane_fcmp_lane
    import lane_fcmp_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output cmp_out_e     outc_o,
    output logic         snan_o
);

    localparam int MAG_W = W - 1;

    logic             a_nan, b_nan, a_snan, b_snan;
    logic             a_neg, b_neg;
    logic [MAG_W-1:0] a_mag, b_mag;

    always_comb begin
        a_neg  = a_i[W-1];
        b_neg  = b_i[W-1];
        a_mag  = a_i[MAG_W-1:0];
        b_mag  = b_i[MAG_W-1:0];
        a_nan  = (&a_i[FW +: EW]) && (|a_i[FW-1:0]);
        b_nan  = (&b_i[FW +: EW]) && (|b_i[FW-1:0]);
        a_snan = a_nan && !a_i[FW-1];
        b_snan = b_nan && !b_i[FW-1];
        snan_o = a_snan || b_snan;

        if (a_nan || b_nan) begin
            outc_o = CMP_UN;
        end else if ((a_mag == '0) && (b_mag == '0)) begin
            outc_o = CMP_EQ;
        end else if (a_i == b_i) begin
            outc_o = CMP_EQ;
        end else if (a_neg != b_neg) begin
            outc_o = a_neg ? CMP_LT : CMP_GT;
        end else if ((a_mag > b_mag) != a_neg) begin
            outc_o = CMP_GT;
        end else begin
            outc_o = CMP_LT;
        end
    end

endmodule

// File: rtl/lane_fcmp_rel.sv
module lane_fcmp_rel
    import lane_fcmp_pkg::*;
(
    input  cmp_out_e outc_i,
    input  rel_e     rel_i,
    output logic     hit_o
);

    always_comb begin
        case (rel_i)
            REL_EQ:  hit_o = (outc_i == CMP_EQ);
            REL_GT:  hit_o = (outc_i == CMP_GT);
            REL_LT:  hit_o = (outc_i == CMP_LT);
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/lane_fcmp_crfield.sv
module lane_fcmp_crfield
    import lane_fcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              vec_i,
    input  logic [1:0]        rel_i,
    input  logic [FIDX_W-1:0] field_i,
    input  logic [OP_W-1:0]   opa_i,
    input  logic [OP_W-1:0]   opb_i,
    output logic [CR_W-1:0]   cr_o,
    output logic              inv_o
);

    cmp_out_e          outc [LANES];
    logic [LANES-1:0]  hit;
    logic [LANES-1:0]  snan;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            lane_fcmp_lane u_cmp (
                .a_i    (opa_i[g*WORD_W +: WORD_W]),
                .b_i    (opb_i[g*WORD_W +: WORD_W]),
                .outc_o (outc[g]),
                .snan_o (snan[g])
            );
            lane_fcmp_rel u_rel (
                .outc_i (outc[g]),
                .rel_i  (rel_e'(rel_i)),
                .hit_o  (hit[g])
            );
        end
    endgenerate

    state_t            st_d, st_q;
    logic [FIDX_W-1:0] slot_d;
    logic [SH_W-1:0]   shamt_d;
    logic [NIB_W-1:0]  nib_d;
    logic              inv_now_d;
    logic [CR_W-1:0]   mask_d;

    // lane 0 is the low word, lane 1 the high word
    always_comb begin
        st_d    = st_q;
        slot_d  = FIDX_W'(FIELDS - 1) - field_i;
        shamt_d = SH_W'(slot_d) * SH_W'(NIB_W);
        mask_d  = CR_W'({NIB_W{1'b1}}) << shamt_d;
        if (vec_i) begin
            nib_d     = {hit[1], hit[0], hit[1] | hit[0], hit[1] & hit[0]};
            inv_now_d = |snan;
        end else begin
            nib_d     = {1'b0, hit[0], 2'b00};
            inv_now_d = snan[0];
        end
        if (valid_i) begin
            st_d.cr  = (st_q.cr & ~mask_d) | (CR_W'(nib_d) << shamt_d);
            st_d.inv = st_q.inv | inv_now_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cr_o  = st_q.cr;
    assign inv_o = st_q.inv;

endmodule

// File: rtl/lane_fcmp_chk.sv
module lane_fcmp_chk
    import lane_fcmp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic              vec_i,
    input logic [FIDX_W-1:0] field_i,
    input logic [OP_W-1:0]   opa_i,
    input logic [OP_W-1:0]   opb_i,
    input logic [CR_W-1:0]   cr_o,
    input logic              inv_o
);

    function automatic logic [CR_W-1:0] fmask(logic [FIDX_W-1:0] f);
        return CR_W'({NIB_W{1'b1}}) << ((FIELDS - 1 - int'(f)) * NIB_W);
    endfunction

    function automatic logic [NIB_W-1:0] fnib(logic [CR_W-1:0] cr, logic [FIDX_W-1:0] f);
        return cr[(FIELDS - 1 - int'(f)) * NIB_W +: NIB_W];
    endfunction

    function automatic logic sig_nan(logic [WORD_W-1:0] x);
        return (x[FRAC_W +: EXP_W] == '1) && (x[FRAC_W-2:0] != '0) && !x[FRAC_W-1];
    endfunction

    function automatic logic any_snan(logic [OP_W-1:0] a, logic [OP_W-1:0] b, logic v);
        logic lo, hi;
        lo = sig_nan(a[WORD_W-1:0]) || sig_nan(b[WORD_W-1:0]);
        hi = sig_nan(a[OP_W-1:WORD_W]) || sig_nan(b[OP_W-1:WORD_W]);
        return v ? (lo || hi) : lo;
    endfunction

    p_reset_clears_r10: assert property (@(posedge clk)
        !rst_n |=> (cr_o == '0 && !inv_o));

    p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(cr_o) && $stable(inv_o)));

    p_others_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> ((cr_o & ~fmask($past(field_i))) == ($past(cr_o) & ~fmask($past(field_i)))));

    p_scalar_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !vec_i) |=> (fnib(cr_o, $past(field_i)) == 4'h0 || fnib(cr_o, $past(field_i)) == 4'h4));

    p_vec_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && vec_i) |=>
            (fnib(cr_o, $past(field_i))[1] == (fnib(cr_o, $past(field_i))[3] | fnib(cr_o, $past(field_i))[2]) &&
             fnib(cr_o, $past(field_i))[0] == (fnib(cr_o, $past(field_i))[3] & fnib(cr_o, $past(field_i))[2])));

    p_sticky_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inv_o |=> inv_o);

    p_quiet_no_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !inv_o && !any_snan(opa_i, opb_i, vec_i)) |=> !inv_o);

endmodule

bind lane_fcmp_crfield lane_fcmp_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .vec_i   (vec_i),
    .field_i (field_i),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .cr_o    (cr_o),
    .inv_o   (inv_o)
);

// File: tb/lane_fcmp_crfield_test.sv
module lane_fcmp_crfield_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        vec_i = 1'b0;
    logic [1:0]  rel_i = 2'd0;
    logic [2:0]  field_i = 3'd0;
    logic [63:0] opa_i = '0;
    logic [63:0] opb_i = '0;
    logic [31:0] cr_o;
    logic        inv_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit started = 0;
    bit done = 0;

    logic [31:0] m_cr = '0;
    logic        m_inv = 1'b0;

    always #10 clk = ~clk;

    lane_fcmp_crfield uut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .vec_i(vec_i),
        .rel_i(rel_i), .field_i(field_i), .opa_i(opa_i), .opb_i(opb_i),
        .cr_o(cr_o), .inv_o(inv_o)
    );

    function automatic bit is_nan(logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    function automatic bit is_snan(logic [31:0] x);
        return is_nan(x) && !x[22];
    endfunction

    function automatic real to_real(logic [31:0] x);
        int  e = int'(x[30:23]);
        real v = real'(x[22:0]);
        int  p;
        if (e != 0) begin
            v = v + 8388608.0;
            p = e - 150;
        end else begin
            p = -149;
        end
        if (p > 0) repeat (p) v = v * 2.0;
        else repeat (-p) v = v / 2.0;
        return x[31] ? -v : v;
    endfunction

    function automatic int ref_hit(logic [31:0] a, logic [31:0] b, logic [1:0] r);
        real ra, rb;
        if (is_nan(a) || is_nan(b)) return 0;
        ra = to_real(a);
        rb = to_real(b);
        case (r)
            2'd0: return (ra == rb) ? 1 : 0;
            2'd1: return (ra > rb) ? 1 : 0;
            2'd2: return (ra < rb) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        int lo, hi, nib, pos;
        cyc++;
        started = 1;
        if (!rst_n) begin
            m_cr  = '0;
            m_inv = 1'b0;
        end else if (valid_i) begin
            lo = ref_hit(opa_i[31:0], opb_i[31:0], rel_i);
            hi = ref_hit(opa_i[63:32], opb_i[63:32], rel_i);
            if (vec_i) begin
                nib = hi * 8 + lo * 4 + (hi | lo) * 2 + (hi & lo);
                if (is_snan(opa_i[31:0]) || is_snan(opb_i[31:0]) ||
                    is_snan(opa_i[63:32]) || is_snan(opb_i[63:32])) m_inv = 1'b1;
            end else begin
                nib = lo * 4;
                if (is_snan(opa_i[31:0]) || is_snan(opb_i[31:0])) m_inv = 1'b1;
            end
            pos  = (7 - int'(field_i)) * 4;
            m_cr = (m_cr & ~(32'hF << pos)) | (32'(nib) << pos);
        end
        if (cyc > 5000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual cycle %0d expected under 5000", cyc);
            report();
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (cr_o !== m_cr || inv_o !== m_inv) begin
                errors++;
                $display("FAIL R9 model: actual cr=%08h inv=%0b expected cr=%08h inv=%0b",
                         cr_o, inv_o, m_cr, m_inv);
            end
        end
    end

    task automatic report();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic step(bit v, logic [1:0] r, logic [2:0] f, logic [63:0] a, logic [63:0] b);
        valid_i = 1'b1;
        vec_i   = v;
        rel_i   = r;
        field_i = f;
        opa_i   = a;
        opb_i   = b;
        @(posedge clk);
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    localparam logic [31:0] ONE  = 32'h3F80_0000;
    localparam logic [31:0] TWO  = 32'h4000_0000;
    localparam logic [31:0] THR  = 32'h4040_0000;
    localparam logic [31:0] MONE = 32'hBF80_0000;
    localparam logic [31:0] MTWO = 32'hC000_0000;
    localparam logic [31:0] QNAN = 32'h7FC0_0000;
    localparam logic [31:0] SNAN = 32'h7F80_0001;

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset cr", cr_o, 32'h0);
        chk("R10 reset inv", {31'b0, inv_o}, 32'h0);
        rst_n = 1'b1;

        step(0, 2'd0, 3'd0, {32'h0, ONE}, {32'h0, ONE});
        chk("R1 R3 scalar eq field0", cr_o, 32'h4000_0000);

        step(0, 2'd1, 3'd7, {32'h1234_5678, TWO}, {SNAN, ONE});
        chk("R1 R3 scalar gt field7, high ignored", cr_o, 32'h4000_0004);
        chk("R1 R7 high snan ignored in scalar", {31'b0, inv_o}, 32'h0);

        step(0, 2'd2, 3'd3, {32'h0, MTWO}, {32'h0, MONE});
        chk("R6 negatives reversed lt", cr_o, 32'h4004_0004);

        step(0, 2'd1, 3'd3, {32'h0, MTWO}, {32'h0, MONE});
        chk("R6 negatives reversed gt false", cr_o, 32'h4000_0004);

        step(0, 2'd0, 3'd5, {32'h0, 32'h0}, {32'h0, 32'h8000_0000});
        chk("R6 signed zeros equal", cr_o, 32'h4000_0404);

        step(0, 2'd0, 3'd0, {32'h0, QNAN}, {32'h0, QNAN});
        chk("R5 nan eq false", cr_o, 32'h0000_0404);
        chk("R7 quiet nan no invalid", {31'b0, inv_o}, 32'h0);

        step(0, 2'd3, 3'd5, {32'h0, ONE}, {32'h0, ONE});
        chk("R4 code 3 never holds", cr_o, 32'h0000_0004);

        step(1, 2'd1, 3'd1, {THR, ONE}, {ONE, THR});
        chk("R2 vector high only", cr_o, 32'h0A00_0004);

        step(1, 2'd2, 3'd1, {THR, ONE}, {ONE, THR});
        chk("R2 vector low only", cr_o, 32'h0600_0004);

        step(1, 2'd0, 3'd1, {ONE, TWO}, {ONE, TWO});
        chk("R2 vector both", cr_o, 32'h0F00_0004);

        step(1, 2'd0, 3'd1, {QNAN, TWO}, {ONE, TWO});
        chk("R5 vector high nan", cr_o, 32'h0600_0004);
        chk("R7 vector quiet nan no invalid", {31'b0, inv_o}, 32'h0);

        step(1, 2'd1, 3'd2, {SNAN, TWO}, {ONE, ONE});
        chk("R2 R5 vector snan lane", cr_o, 32'h0660_0004);
        chk("R7 snan raises invalid", {31'b0, inv_o}, 32'h1);

        step(0, 2'd0, 3'd0, {32'h0, ONE}, {32'h0, ONE});
        chk("R8 invalid sticky", {31'b0, inv_o}, 32'h1);
        chk("R3 field0 rewritten", cr_o, 32'h4660_0004);

        step(0, 2'd1, 3'd4, {32'h0, 32'h0000_0001}, {32'h0, 32'h8000_0000});
        chk("R6 denormal above zero", cr_o, 32'h4660_4004);

        opa_i = {MONE, MONE};
        opb_i = {ONE, ONE};
        vec_i = 1'b1;
        rel_i = 2'd2;
        field_i = 3'd6;
        repeat (3) @(negedge clk);
        chk("R9 idle hold cr", cr_o, 32'h4660_4004);

        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 reset clears cr", cr_o, 32'h0);
        chk("R10 reset clears inv", {31'b0, inv_o}, 32'h0);
        rst_n = 1'b1;

        step(0, 2'd0, 3'd6, {32'h0, 32'h7FA0_0000}, {32'h0, ONE});
        chk("R7 scalar low snan", {31'b0, inv_o}, 32'h1);
        chk("R5 scalar snan false", cr_o, 32'h0);

        for (int i = 0; i < 8; i++) begin
            step(0, 2'd0, 3'(i), {32'h0, TWO}, {32'h0, TWO});
        end
        chk("R3 all fields set", cr_o, 32'h4444_4444);

        @(negedge clk);
        report();
    end

endmodule